// File: doc/BRIEF.md
# Endpoint Receive FIFO with Packet Length Ring

This block buffers received packet data for one device endpoint. The serial-engine side writes bytes one at a time and marks the last byte of each packet. The firmware side reads the bytes back in arrival order. Bytes of a packet become visible to the reader only when that packet completes. The completed packet's byte count then goes into a two-entry ring. Firmware reads the length of the oldest unread packet and pops it once that packet has been consumed.

A control register sets the following:
- the buffer capacity, using a 2-bit size code together with an isochronous-mode bit;
- an arm bit that enables the write side;
- a flush bit that clears itself.

A feature input changes two of the non-isochronous size codes. Status bits record these events:
- a setup packet arriving;
- a packet lost because the ring was full;
- an aborted packet;
- a byte dropped because the buffer was full;
- an accepted packet.

A sequence bit toggles with every accepted packet. A flush or an incoming setup packet empties the buffer and the ring. The flush also clears the event bits but leaves the sequence bit unchanged.

Top module: `ep_rx_fifo`

## Requirements
- R1: After reset, ctrl_o reads 0x04 (armed, size code 0, non-isochronous), stat_o reads 0x00, flag_o reads 0x01 and both count outputs read 0.
- R2: Bytes of a packet whose last byte has not been written are not visible. flag_o[0] (empty) stays 1 while only such bytes are held.
- R3: Bytes come out of rd_data_o in write order, one per rd_en_i. Both pointers wrap at the selected capacity.
- R4: Capacity follows the size code ctrl[6:5] and the iso bit ctrl[3].
  - With iso=1, codes 0/1/2/3 give 64/256/512/1024 bytes.
  - With iso=0, codes 0/1 give 16/64 bytes. Code 2 gives 8 bytes and code 3 gives 32 bytes when feat_i=1, and both give 64 bytes when feat_i=0.
  - flag_o[1] (full) is 1 when the buffer holds capacity bytes. A byte written while full is dropped and sets stat_o[3].
- R5: A completed packet pushes its byte count into a two-entry ring. The count outputs show the oldest entry. A rd_done_i pulse pops that entry. An empty ring reads 0.
- R6: The count is 10 bits wide. cnt_hi_o[1:0] holds count bits 9:8 and cnt_hi_o[7:2] reads 0. cnt_lo_o holds count bits 7:0.
- R7: A packet that completes while the ring holds two entries is discarded entirely and sets stat_o[1]. Data and counts already queued are unchanged.
- R8: Writing ctrl bit 7 makes ctrl_o[7] read 1 for exactly one cycle. The flush then takes effect:
  - the buffer and the ring are emptied;
  - flag_o reads 0x01;
  - stat_o[4:0] are cleared;
  - stat_o[5] (sequence) keeps its value.
- R9: A setup_i pulse empties the buffer and the ring and sets stat_o[0].
- R10: Each accepted packet toggles stat_o[5] and sets stat_o[4].
- R11: A wr_abort_i pulse discards the bytes of the incomplete packet and sets stat_o[2]. Committed data is kept.
- R12: With the arm bit ctrl[2] at 0, written bytes and packet ends have no effect.
- R13: Control bits 4, 1 and 0 are reserved. They read 0 whatever value is written.
- R14: A rd_en_i while empty sets flag_o[2] and does not move the read pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| feat_i | input | 1 | Enables the small non-iso sizes for codes 2 and 3 |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data |
| ctrl_o | output | 8 | Control readback: flush[7], size[6:5], iso[3], arm[2] |
| stat_o | output | 8 | Status: seq[5], ack[4], err[3], void[2], ovw[1], setup[0] |
| flag_o | output | 8 | Flags: underflow[2], full[1], empty[0] |
| setup_i | input | 1 | Setup packet start, clears buffer |
| wr_valid_i | input | 1 | Write byte strobe |
| wr_data_i | input | 8 | Write byte |
| wr_last_i | input | 1 | Byte is the last of its packet |
| wr_abort_i | input | 1 | Discard the incomplete packet |
| rd_en_i | input | 1 | Consume one byte |
| rd_done_i | input | 1 | Pop the oldest packet count |
| rd_data_o | output | 8 | Byte at the read pointer |
| cnt_hi_o | output | 8 | Count bits 9:8 in [1:0] |
| cnt_lo_o | output | 8 | Count bits 7:0 |

## Verification
The bound checker watches properties that hold on every cycle:
- the flush bit clears one cycle after it is set;
- after a flush the flags are clean and the sequence bit is kept;
- reserved control bits and the upper count bits stay zero;
- an unfinished packet leaves the empty flag set;
- a setup pulse clears the buffer;
- a disarmed block stays empty.

Other behaviours can only be shown by the bench scenarios:
- byte ordering and pointer wrap at each of the ten capacity settings;
- which packet length the ring shows and the order in which entries pop;
- loss of a third packet when the ring is full;
- recovery after an abort.

// File: rtl/ep_rx_fifo_pkg.sv
package ep_rx_fifo_pkg;
  localparam int CAP_W = 11;

  localparam int ST_SETUP = 0;
  localparam int ST_OVW   = 1;
  localparam int ST_VOID  = 2;
  localparam int ST_ERR   = 3;
  localparam int ST_ACK   = 4;
  localparam int ST_SEQ   = 5;

  function automatic logic [CAP_W-1:0] cap_of(input logic [1:0] sz, input logic iso,
                                              input logic feat);
    logic [CAP_W-1:0] c;
    if (iso) begin
      case (sz)
        2'd0:    c = 11'd64;
        2'd1:    c = 11'd256;
        2'd2:    c = 11'd512;
        default: c = 11'd1024;
      endcase
    end else begin
      case (sz)
        2'd0:    c = 11'd16;
        2'd1:    c = 11'd64;
        2'd2:    c = feat ? 11'd8  : 11'd64;
        default: c = feat ? 11'd32 : 11'd64;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/ep_rx_fifo_ptrs.sv
module ep_rx_fifo_ptrs #(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [AW:0]   cap_i,
  input  logic          wr_i,
  input  logic          cmt_i,
  input  logic          rew_i,
  input  logic          rd_i,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [AW:0]   used_o,
  output logic [AW:0]   pend_o
);
  localparam logic [AW:0]   ONE_W = 1;
  localparam logic [AW-1:0] ONE_P = 1;

  logic [AW-1:0] wr_q, cmt_q, rd_q;
  logic [AW:0]   used_q, pend_q;
  logic [AW:0]   inc_w, dec_r;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p, input logic [AW:0] cap);
    return (({1'b0, p} + ONE_W) == cap) ? '0 : p + ONE_P;
  endfunction

  assign inc_w = wr_i ? ONE_W : '0;
  assign dec_r = rd_i ? ONE_W : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      cmt_q  <= '0;
      rd_q   <= '0;
      used_q <= '0;
      pend_q <= '0;
    end else if (clr_i) begin
      wr_q   <= '0;
      cmt_q  <= '0;
      rd_q   <= '0;
      used_q <= '0;
      pend_q <= '0;
    end else begin
      if (rd_i) rd_q <= bump(rd_q, cap_i);
      if (rew_i) begin
        // drop every byte written since the last commit
        wr_q   <= cmt_q;
        pend_q <= '0;
        used_q <= used_q - pend_q - dec_r;
      end else begin
        if (wr_i) wr_q <= bump(wr_q, cap_i);
        if (cmt_i) begin
          cmt_q  <= wr_i ? bump(wr_q, cap_i) : wr_q;
          pend_q <= '0;
        end else begin
          pend_q <= pend_q + inc_w;
        end
        used_q <= used_q + inc_w - dec_r;
      end
    end
  end

  assign wr_ptr_o = wr_q;
  assign rd_ptr_o = rd_q;
  assign used_o   = used_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/ep_rx_fifo_cnt_ring.sv
module ep_rx_fifo_cnt_ring #(
  parameter int CW    = 10,
  parameter int DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [CW-1:0] len_i,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] head_o
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IW:0]   DEP_W = (IW+1)'(DEPTH);
  localparam logic [IW:0]   ONE_N = 1;
  localparam logic [IW-1:0] LAST  = (IW)'(DEPTH - 1);
  localparam logic [IW-1:0] ONE_I = 1;

  logic [CW-1:0] ent_q [DEPTH];
  logic [IW-1:0] wi_q, ri_q;
  logic [IW:0]   n_q;
  logic          push_ok, pop_ok;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == LAST) ? '0 : i + ONE_I;
  endfunction

  assign full_o  = (n_q == DEP_W);
  assign empty_o = (n_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
      wi_q <= '0;
      ri_q <= '0;
      n_q  <= '0;
    end else if (clr_i) begin
      wi_q <= '0;
      ri_q <= '0;
      n_q  <= '0;
    end else begin
      if (push_ok) begin
        ent_q[wi_q] <= len_i;
        wi_q        <= nxt(wi_q);
      end
      if (pop_ok) ri_q <= nxt(ri_q);
      n_q <= n_q + (push_ok ? ONE_N : '0) - (pop_ok ? ONE_N : '0);
    end
  end

  assign head_o = empty_o ? '0 : ent_q[ri_q];
endmodule

// File: rtl/ep_rx_fifo_regs.sv
module ep_rx_fifo_regs (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       ev_setup_i,
  input  logic       ev_ovw_i,
  input  logic       ev_void_i,
  input  logic       ev_err_i,
  input  logic       ev_ack_i,
  input  logic       ev_uf_i,
  output logic       flush_o,
  output logic [1:0] size_o,
  output logic       iso_o,
  output logic       arm_o,
  output logic       uf_o,
  output logic [7:0] ctrl_o,
  output logic [7:0] stat_o
);
  import ep_rx_fifo_pkg::*;

  logic       flush_q, iso_q, arm_q, uf_q, seq_q;
  logic [1:0] size_q;
  logic [4:0] ev_q;
  logic       unused_rsvd;

  assign unused_rsvd = ^{wdata_i[4], wdata_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= 1'b0;
      size_q  <= 2'd0;
      iso_q   <= 1'b0;
      arm_q   <= 1'b1;
    end else begin
      // flush self-clears even if written again while active
      flush_q <= we_i & wdata_i[7] & ~flush_q;
      if (we_i) begin
        size_q <= wdata_i[6:5];
        iso_q  <= wdata_i[3];
        arm_q  <= wdata_i[2];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q  <= '0;
      uf_q  <= 1'b0;
      seq_q <= 1'b0;
    end else if (flush_q) begin
      ev_q <= '0;
      uf_q <= 1'b0;
    end else begin
      if (ev_setup_i) ev_q[ST_SETUP] <= 1'b1;
      if (ev_ovw_i)   ev_q[ST_OVW]   <= 1'b1;
      if (ev_void_i)  ev_q[ST_VOID]  <= 1'b1;
      if (ev_err_i)   ev_q[ST_ERR]   <= 1'b1;
      if (ev_ack_i) begin
        ev_q[ST_ACK] <= 1'b1;
        seq_q        <= ~seq_q;
      end
      if (ev_setup_i)   uf_q <= 1'b0;
      else if (ev_uf_i) uf_q <= 1'b1;
    end
  end

  assign flush_o = flush_q;
  assign size_o  = size_q;
  assign iso_o   = iso_q;
  assign arm_o   = arm_q;
  assign uf_o    = uf_q;
  assign ctrl_o  = {flush_q, size_q, 1'b0, iso_q, arm_q, 2'b00};
  assign stat_o  = {2'b00, seq_q, ev_q};
endmodule

// File: rtl/ep_rx_fifo.sv
module ep_rx_fifo #(
  parameter int MEM_DEPTH = 1024,
  parameter int CW        = 10,
  parameter int RING      = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       feat_i,
  input  logic       ctrl_we_i,
  input  logic [7:0] ctrl_wdata_i,
  output logic [7:0] ctrl_o,
  output logic [7:0] stat_o,
  output logic [7:0] flag_o,
  input  logic       setup_i,
  input  logic       wr_valid_i,
  input  logic [7:0] wr_data_i,
  input  logic       wr_last_i,
  input  logic       wr_abort_i,
  input  logic       rd_en_i,
  input  logic       rd_done_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] cnt_hi_o,
  output logic [7:0] cnt_lo_o
);
  import ep_rx_fifo_pkg::*;

  localparam int AW = $clog2(MEM_DEPTH);

  logic          flush, iso, arm, uf;
  logic [1:0]    size;
  logic [AW:0]   cap, used, pend, held;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, live;
  logic          byte_try, cmt_try, ovw, wr_store, err_ev, cmt, rew, rd, uf_ev, pop;
  logic          ring_full, ring_empty;
  logic [CW-1:0] head, len;
  logic [7:0]    mem_q [MEM_DEPTH];

  assign cap   = (AW+1)'(cap_of(size, iso, feat_i));
  assign full  = (used == cap);
  assign held  = used - pend;
  assign empty = (held == '0);
  assign live  = ~flush & ~setup_i;

  assign byte_try = live & arm & wr_valid_i & ~wr_abort_i;
  assign cmt_try  = byte_try & wr_last_i;
  assign ovw      = cmt_try & ring_full;
  assign wr_store = byte_try & ~full & ~ovw;
  assign err_ev   = byte_try & full & ~ovw;
  assign cmt      = cmt_try & ~ring_full;
  assign rew      = (live & wr_abort_i) | ovw;
  assign rd       = live & rd_en_i & ~empty;
  assign uf_ev    = live & rd_en_i & empty;
  assign pop      = live & rd_done_i;
  assign len      = CW'(pend + (wr_store ? (AW+1)'(1) : '0));

  ep_rx_fifo_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .ev_setup_i (setup_i & ~flush),
    .ev_ovw_i   (ovw),
    .ev_void_i  (live & wr_abort_i),
    .ev_err_i   (err_ev),
    .ev_ack_i   (cmt),
    .ev_uf_i    (uf_ev),
    .flush_o    (flush),
    .size_o     (size),
    .iso_o      (iso),
    .arm_o      (arm),
    .uf_o       (uf),
    .ctrl_o     (ctrl_o),
    .stat_o     (stat_o)
  );

  ep_rx_fifo_ptrs #(.AW(AW)) u_ptrs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (flush | setup_i),
    .cap_i    (cap),
    .wr_i     (wr_store),
    .cmt_i    (cmt),
    .rew_i    (rew),
    .rd_i     (rd),
    .wr_ptr_o (wr_ptr),
    .rd_ptr_o (rd_ptr),
    .used_o   (used),
    .pend_o   (pend)
  );

  ep_rx_fifo_cnt_ring #(.CW(CW), .DEPTH(RING)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (flush | setup_i),
    .push_i  (cmt),
    .pop_i   (pop),
    .len_i   (len),
    .full_o  (ring_full),
    .empty_o (ring_empty),
    .head_o  (head)
  );

  always_ff @(posedge clk_i) begin
    if (wr_store) mem_q[wr_ptr] <= wr_data_i;
  end

  logic unused_ring;
  assign unused_ring = ring_empty;

  assign rd_data_o = mem_q[rd_ptr];
  assign flag_o    = {5'b0, uf, full, empty};
  assign cnt_hi_o  = {{(16-CW){1'b0}}, head[CW-1:8]};
  assign cnt_lo_o  = head[7:0];
endmodule

// File: rtl/ep_rx_fifo_chk.sv
module ep_rx_fifo_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       feat_i,
  input logic       ctrl_we_i,
  input logic [7:0] ctrl_wdata_i,
  input logic [7:0] ctrl_o,
  input logic [7:0] stat_o,
  input logic [7:0] flag_o,
  input logic       setup_i,
  input logic       wr_valid_i,
  input logic [7:0] wr_data_i,
  input logic       wr_last_i,
  input logic       wr_abort_i,
  input logic       rd_en_i,
  input logic       rd_done_i,
  input logic [7:0] rd_data_o,
  input logic [7:0] cnt_hi_o,
  input logic [7:0] cnt_lo_o
);
  assert_flush_self_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[7] |=> !ctrl_o[7]);

  assert_flush_flags_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[7] |=> (flag_o == 8'h01) && (stat_o[4:0] == 5'd0));

  assert_flush_keeps_seq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[7] |=> stat_o[5] == $past(stat_o[5]));

  assert_rsvd_zero_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o[4] == 1'b0) && (ctrl_o[1:0] == 2'b00));

  assert_cnt_hi_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_hi_o[7:2] == 6'd0);

  assert_partial_hidden_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[0] && wr_valid_i && !wr_last_i) |=> flag_o[0]);

  assert_setup_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (setup_i && !ctrl_o[7]) |=> (stat_o[0] && flag_o[0] && cnt_lo_o == 8'd0));

  assert_disarmed_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[2] && flag_o[0] && !ctrl_we_i) |=> flag_o[0]);

  assert_underflow_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[0] && rd_en_i && !setup_i && !ctrl_o[7]) |=> flag_o[2]);
endmodule

bind ep_rx_fifo ep_rx_fifo_chk u_chk (.*);

// File: tb/sim_ep_rx_fifo.sv
`timescale 1ns/1ps
module sim_ep_rx_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       feat = 1'b1;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] ctrl, stat, flag, rdata, chi, clo;
  logic       setup = 1'b0, wv = 1'b0, wl = 1'b0, wab = 1'b0, ren = 1'b0, rdone = 1'b0;
  logic [7:0] wd = '0;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ep_rx_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n), .feat_i(feat), .ctrl_we_i(we), .ctrl_wdata_i(wdata),
    .ctrl_o(ctrl), .stat_o(stat), .flag_o(flag), .setup_i(setup), .wr_valid_i(wv),
    .wr_data_i(wd), .wr_last_i(wl), .wr_abort_i(wab), .rd_en_i(ren), .rd_done_i(rdone),
    .rd_data_o(rdata), .cnt_hi_o(chi), .cnt_lo_o(clo)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wb(input logic [7:0] d, input bit last);
    wv = 1'b1; wd = d; wl = last; step(); wv = 1'b0; wl = 1'b0;
  endtask

  task automatic rb(input logic [7:0] e, input string tag);
    chk(rdata == e, tag, rdata, e);
    ren = 1'b1; step(); ren = 1'b0;
  endtask

  task automatic pop(); rdone = 1'b1; step(); rdone = 1'b0; endtask

  task automatic wctl(input logic [7:0] v); we = 1'b1; wdata = v; step(); we = 1'b0; endtask

  task automatic do_flush(input logic [7:0] base);
    wctl(base | 8'h80);
    chk(ctrl[7] == 1'b1, "R8 flush bit visible", ctrl[7], 1);
    step();
    chk(ctrl[7] == 1'b0, "R8 flush self-clear", ctrl[7], 0);
    chk(flag == 8'h01, "R8 flags after flush", flag, 8'h01);
  endtask

  function automatic int bcap(input int sz, input int iso, input int ft);
    if (iso != 0) return 64 << (sz == 0 ? 0 : sz + 1);
    case (sz)
      0: return 16;
      1: return 64;
      2: return ft ? 8 : 64;
      default: return ft ? 32 : 64;
    endcase
  endfunction

  task automatic sweep(input int sz, input int iso, input int ft);
    int c, h, seed, cnt;
    logic [7:0] base;
    feat = ft[0];
    base = {1'b0, sz[1:0], 1'b0, iso[0], 1'b1, 2'b00};
    do_flush(base);
    c = bcap(sz, iso, ft); h = c / 2; seed = sz * 16 + iso * 64 + ft;
    for (int i = 0; i < c; i++) wb(8'(seed + i), (i % h) == h - 1);
    chk(flag[1] == 1'b1, "R4 full at capacity", flag, 2);
    wb(8'hEE, 1'b0);
    chk(stat[3] == 1'b1, "R4 byte dropped when full", stat, 8);
    cnt = {chi[1:0], clo};
    chk(cnt == h, "R5 oldest count", cnt, h);
    for (int i = 0; i < h; i++) rb(8'(seed + i), "R3 order A");
    pop();
    for (int i = 0; i < h; i++) wb(8'(seed + c + i), i == h - 1);
    chk(flag[1] == 1'b1, "R3 full after wrap", flag, 2);
    for (int i = h; i < c; i++) rb(8'(seed + i), "R3 order B");
    pop();
    for (int i = 0; i < h; i++) rb(8'(seed + c + i), "R3 wrapped data");
    pop();
    chk(flag[0] == 1'b1, "R3 empty at end", flag, 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt;
    bit s;
    step(); step();
    rst_n = 1'b1;
    step();
    chk(ctrl == 8'h04, "R1 ctrl reset", ctrl, 8'h04);
    chk(stat == 8'h00, "R1 stat reset", stat, 0);
    chk(flag == 8'h01, "R1 flag reset", flag, 1);
    chk({chi, clo} == 16'd0, "R1 count reset", {chi, clo}, 0);

    // packet ordering, count ring, overwrite
    for (int i = 0; i < 3; i++) wb(8'(8'h10 + i), 1'b0);
    chk(flag[0] == 1'b1, "R2 partial hidden", flag, 1);
    wb(8'h13, 1'b1);
    chk(flag[0] == 1'b0, "R2 visible after last", flag, 0);
    chk(clo == 8'd4, "R5 first count", clo, 4);
    chk(stat[5] == 1'b1 && stat[4] == 1'b1, "R10 seq and ack", stat, 8'h30);
    for (int i = 0; i < 5; i++) wb(8'(8'h20 + i), i == 4);
    chk(clo == 8'd4, "R5 oldest kept", clo, 4);
    chk(stat[5] == 1'b0, "R10 seq toggle", stat[5], 0);
    wb(8'h30, 1'b0); wb(8'h31, 1'b1);
    chk(stat[1] == 1'b1, "R7 overwrite flag", stat, 2);
    chk(stat[5] == 1'b0, "R7 seq unchanged", stat[5], 0);
    for (int i = 0; i < 4; i++) rb(8'(8'h10 + i), "R7 pkt1 data");
    pop();
    chk(clo == 8'd5, "R5 pop advances", clo, 5);
    for (int i = 0; i < 5; i++) rb(8'(8'h20 + i), "R7 pkt2 data");
    chk(flag[0] == 1'b1, "R7 third packet gone", flag, 1);
    pop();
    chk(clo == 8'd0, "R5 empty ring reads 0", clo, 0);

    // abort
    do_flush(8'h04);
    wb(8'h01, 1'b0); wb(8'h02, 1'b0); wb(8'h03, 1'b0);
    wab = 1'b1; step(); wab = 1'b0;
    chk(stat[2] == 1'b1, "R11 void set", stat, 4);
    chk(flag[0] == 1'b1, "R11 empty after abort", flag, 1);
    wb(8'h11, 1'b0); wb(8'h22, 1'b1);
    chk(clo == 8'd2, "R11 count after abort", clo, 2);
    rb(8'h11, "R11 data"); rb(8'h22, "R11 data");
    pop();

    // setup clears
    wb(8'h44, 1'b0); wb(8'h45, 1'b1);
    setup = 1'b1; step(); setup = 1'b0;
    chk(stat[0] == 1'b1, "R9 setup bit", stat, 1);
    chk(flag[0] == 1'b1 && clo == 8'd0, "R9 cleared", {flag, clo}, 16'h0100);
    wb(8'h3C, 1'b1);
    rb(8'h3C, "R9 restart data");
    pop();

    // underflow
    do_flush(8'h04);
    ren = 1'b1; step(); ren = 1'b0;
    chk(flag == 8'h05, "R14 underflow flag", flag, 8'h05);
    wb(8'hA5, 1'b1);
    rb(8'hA5, "R14 pointer unmoved");
    pop();

    // disarmed
    wctl(8'h00);
    wb(8'h77, 1'b0); wb(8'h78, 1'b1);
    chk(flag[0] == 1'b1 && clo == 8'd0, "R12 ignored when disarmed", {flag, clo}, 16'h0100);
    chk(stat[5] == 1'b0, "R12 no seq toggle", stat[5], 0);

    // reserved bits
    wctl(8'h7B);
    chk(ctrl == 8'h68, "R13 reserved read zero", ctrl, 8'h68);
    wctl(8'h04);

    // flush keeps sequence
    wb(8'h50, 1'b1);
    s = stat[5];
    wb(8'h51, 1'b0); wb(8'h52, 1'b0);
    do_flush(8'h04);
    chk(stat[4:0] == 5'd0, "R8 status cleared", stat, 0);
    chk(stat[5] == s, "R8 seq preserved", stat[5], s);
    chk(clo == 8'd0, "R8 ring cleared", clo, 0);

    // count split
    do_flush(8'h4C);
    for (int i = 0; i < 300; i++) wb(8'(i), i == 299);
    cnt = {chi[1:0], clo};
    chk(chi == 8'h01 && clo == 8'd44, "R6 count split", {chi, clo}, 300);

    // capacity sweep
    for (int iso = 0; iso < 2; iso++)
      for (int sz = 0; sz < 4; sz++) sweep(sz, iso, 1);
    sweep(2, 0, 0);
    sweep(3, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule